// File: doc/BRIEF.md
# Transmit Trail Trace Identifier Generator

The block keeps a sixteen-byte trail trace identifier that a host writes through a small register port. On the line side it reads those bytes in a fixed circular order and shifts each one out as a serial stream, one bit for each line cycle in which the step enable is high. On its way out, each bit can have its bit order within the byte swapped and can carry a multi-frame alignment marker in its first position. It can also be forced to idle zeros, and it can be inverted as the final step.

The host port and the line serializer each have their own clock. The identifier memory is written and read on the host clock, and the line side reads it directly. Either side therefore keeps working while the clock of the other side is stopped. The identifier memory has no reset: its content after power-up is unknown until the host writes it, and a reset of either side leaves it untouched. The four line-side mode inputs are expected to be stable in the line clock domain.

Top module: `trail_trace_tx`

## Requirements
- R1: With `host_rst_n` high, a host write stores `host_wdata` at entry `host_addr` (0 to 15) on the rising edge of `host_clk`. `host_rdata` always shows the entry selected by `host_addr`. Writes made while `host_rst_n` is low are ignored.
- R2: Reset on either side leaves the identifier memory contents unchanged.
- R3: With reordering off, the bits of a byte go out from storage bit 7 down to storage bit 0, so bit 7 is first on the line.
- R4: With reordering on, the bits of a byte go out from storage bit 0 up to storage bit 7.
- R5: With alignment on, the first serial bit of byte 0 is sent as 1 and the first serial bit of each of bytes 1 to 15 is sent as 0. This holds whatever the reorder setting.
- R6: With idle on, every data bit is zero before the inversion stage.
- R7: Inversion, when on, is applied last, after reordering, alignment and idle. Idle with inversion therefore sends all ones.
- R8: Bytes go out in the order 0, 1, …, 15 and wrap to 0 with no gap. `tx_frame_start` is high exactly while `tx_bit` carries the first serial bit of byte 0.
- R9: On each `line_clk` edge with `line_bit_en` high, `tx_bit` takes the next bit, one cycle of latency. With `line_bit_en` low, `tx_bit`, `tx_frame_start` and the stream position all hold.
- R10: A line reset (`line_rst_n` low on a `line_clk` edge) sets `tx_bit` and `tx_frame_start` to 0 and restarts the stream at the first bit of byte 0.
- R11: Host writes and reads work while `line_clk` is stopped, and the line stream runs correctly while `host_clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host port clock |
| host_rst_n | input | 1 | Host synchronous active-low reset; blocks writes while low |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 4 | Identifier entry for write and read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Content of the entry at `host_addr` |
| line_clk | input | 1 | Line serializer clock |
| line_rst_n | input | 1 | Line synchronous active-low reset |
| line_bit_en | input | 1 | Advance the stream by one bit |
| cfg_reorder | input | 1 | Send storage bit 0 first instead of bit 7 |
| cfg_align | input | 1 | Insert multi-frame marker in each byte's first serial bit |
| cfg_idle | input | 1 | Replace trace data with zeros |
| cfg_invert | input | 1 | Invert the outgoing bits |
| tx_bit | output | 1 | Serial trace bit |
| tx_frame_start | output | 1 | High with the first serial bit of byte 0 |

## Verification
The bound assertions check on every cycle that an idle stream shows only the inversion level. They also check that the alignment marker follows the byte position, that a stalled step freezes output and position, that position 15/7 wraps to 0/0, that the frame flag follows byte 0 bit 0, and that a host write reads back at once. The bit order within a byte, the mapping under both reorder settings, the untouched memory across resets, and the operation with one clock stopped all depend on stored content and on stimulus history. Only the bench's reference model shows these, by comparing the stream with it on every line cycle.

// File: rtl/trail_trace_pkg.sv
// Package: shared constants and types for the trail trace transmitter.
// Assumes an identifier of a power-of-two number of bytes.
package trail_trace_pkg;

    localparam int TRACE_DEPTH = 16;
    localparam int TRACE_WIDTH = 8;

    // Line-side processing controls, grouped so they travel as one value.
    typedef struct packed {
        logic reorder;
        logic align;
        logic idle;
        logic invert;
    } tx_mode_t;

endpackage

// File: rtl/trace_store.sv
// Module: trace_store
// Holds the identifier bytes. It is written and read on the host clock
// and read by the line side with no clock at all, so either clock may be
// stopped. It has no reset, on purpose: the content survives both resets.
module trace_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             host_clk,
    input  logic             host_rst_n,
    input  logic             host_wr_en,
    input  logic [AW-1:0]    host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    input  logic [AW-1:0]    line_addr,
    output logic [WIDTH-1:0] line_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store host data; writes are blocked while the host port is in reset.
    always_ff @(posedge host_clk) begin
        if (host_rst_n && host_wr_en) begin
            mem[host_addr] <= host_wdata;
        end
    end

    // Host read-back of the addressed entry.
    always_comb host_rdata = mem[host_addr];

    // Line-side read of the byte being serialized.
    always_comb line_data = mem[line_addr];

endmodule

// File: rtl/trace_sequencer.sv
// Module: trace_sequencer
// Walks the byte pointer and the bit index through the identifier. It
// advances one bit for each enabled line cycle and wraps from the last bit
// of the last byte to the first bit of byte 0 without a gap.
module trace_sequencer #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int IW = $clog2(WIDTH)
) (
    input  logic          line_clk,
    input  logic          line_rst_n,
    input  logic          step,
    output logic [AW-1:0] byte_ptr,
    output logic [IW-1:0] bit_idx
);

    localparam logic [IW-1:0] LAST_BIT  = IW'(WIDTH - 1);
    localparam logic [AW-1:0] LAST_BYTE = AW'(DEPTH - 1);

    // Advance the stream position; restart at byte 0 bit 0 on reset.
    always_ff @(posedge line_clk) begin
        if (!line_rst_n) begin
            byte_ptr <= '0;
            bit_idx  <= '0;
        end else if (step) begin
            if (bit_idx == LAST_BIT) begin
                bit_idx  <= '0;
                byte_ptr <= (byte_ptr == LAST_BYTE) ? '0 : byte_ptr + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/trace_bit_proc.sv
// Module: trace_bit_proc
// Picks the serial bit for the current position and applies the chain
// in fixed order: reorder select, alignment marker, idle zeros, inversion.
// Purely combinational. The caller registers the result.
module trace_bit_proc
    import trail_trace_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data,
    input  logic [IW-1:0]    bit_idx,
    input  logic             first_byte,
    input  tx_mode_t         mode,
    output logic             bit_out
);

    logic [WIDTH-1:0] msb_order;
    logic [WIDTH-1:0] lsb_order;
    logic             picked;
    logic             marked;
    logic             idled;

    // Lay out both serial orders so that entry k is the k-th bit sent.
    for (genvar k = 0; k < WIDTH; k++) begin : g_order
        assign msb_order[k] = data[WIDTH-1-k];
        assign lsb_order[k] = data[k];
    end

    // Processing chain, in order of application.
    always_comb begin
        picked  = mode.reorder ? lsb_order[bit_idx] : msb_order[bit_idx];
        marked  = (mode.align && (bit_idx == '0)) ? first_byte : picked;
        idled   = mode.idle ? 1'b0 : marked;
        bit_out = idled ^ mode.invert;
    end

endmodule

// File: rtl/trail_trace_tx.sv
// Module: trail_trace_tx (top)
// Transmit trail trace identifier generator: host-written sixteen-byte
// store, line-side sequencer, bit processing chain and a registered
// serial output. Assumes the cfg_* inputs are stable in the line domain.
module trail_trace_tx
    import trail_trace_pkg::*;
#(
    parameter int DEPTH = TRACE_DEPTH,
    parameter int WIDTH = TRACE_WIDTH,
    localparam int AW = $clog2(DEPTH),
    localparam int IW = $clog2(WIDTH)
) (
    input  logic             host_clk,
    input  logic             host_rst_n,
    input  logic             host_wr_en,
    input  logic [AW-1:0]    host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             line_clk,
    input  logic             line_rst_n,
    input  logic             line_bit_en,
    input  logic             cfg_reorder,
    input  logic             cfg_align,
    input  logic             cfg_idle,
    input  logic             cfg_invert,
    output logic             tx_bit,
    output logic             tx_frame_start
);

    logic [AW-1:0]    byte_ptr;
    logic [IW-1:0]    bit_idx;
    logic [WIDTH-1:0] cur_byte;
    logic             next_bit;
    tx_mode_t         mode;

    // Gather the line-side controls.
    always_comb mode = '{reorder: cfg_reorder, align: cfg_align,
                         idle: cfg_idle, invert: cfg_invert};

    trace_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
        .host_clk   (host_clk),
        .host_rst_n (host_rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .line_addr  (byte_ptr),
        .line_data  (cur_byte)
    );

    trace_sequencer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_seq (
        .line_clk   (line_clk),
        .line_rst_n (line_rst_n),
        .step       (line_bit_en),
        .byte_ptr   (byte_ptr),
        .bit_idx    (bit_idx)
    );

    trace_bit_proc #(.WIDTH(WIDTH)) i_proc (
        .data       (cur_byte),
        .bit_idx    (bit_idx),
        .first_byte (byte_ptr == '0),
        .mode       (mode),
        .bit_out    (next_bit)
    );

    // Register the outgoing bit and the frame flag for each enabled step.
    always_ff @(posedge line_clk) begin
        if (!line_rst_n) begin
            tx_bit         <= 1'b0;
            tx_frame_start <= 1'b0;
        end else if (line_bit_en) begin
            tx_bit         <= next_bit;
            tx_frame_start <= (byte_ptr == '0) && (bit_idx == '0);
        end
    end

endmodule

// File: rtl/trail_trace_tx_chk.sv
// Module: trail_trace_tx_chk
// Assertion checker bound to trail_trace_tx. It watches the ports and
// the sequencer position.
module trail_trace_tx_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int IW = $clog2(WIDTH)
) (
    input logic             host_clk,
    input logic             host_rst_n,
    input logic             host_wr_en,
    input logic [AW-1:0]    host_addr,
    input logic [WIDTH-1:0] host_wdata,
    input logic [WIDTH-1:0] host_rdata,
    input logic             line_clk,
    input logic             line_rst_n,
    input logic             line_bit_en,
    input logic             cfg_align,
    input logic             cfg_idle,
    input logic             cfg_invert,
    input logic             tx_bit,
    input logic             tx_frame_start,
    input logic [AW-1:0]    byte_ptr,
    input logic [IW-1:0]    bit_idx
);

    // A write is visible on the read port in the next cycle at the same entry.
    assert_write_readback_R1: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        host_wr_en |=> (!$stable(host_addr) || host_rdata == $past(host_wdata)));

    // The marker bit follows the byte position, before inversion.
    assert_marker_value_R5: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        (line_bit_en && cfg_align && !cfg_idle && bit_idx == '0)
        |=> (tx_bit == (($past(byte_ptr) == '0) ^ $past(cfg_invert))));

    // Idle data shows only the inversion level.
    assert_idle_level_R6: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        (line_bit_en && cfg_idle) |=> (tx_bit == $past(cfg_invert)));

    // The last bit of the last byte is followed by byte 0 bit 0.
    assert_wrap_R8: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        (line_bit_en && byte_ptr == AW'(DEPTH - 1) && bit_idx == IW'(WIDTH - 1))
        |=> (byte_ptr == '0 && bit_idx == '0));

    // The frame flag goes with the first bit of byte 0.
    assert_frame_flag_R8: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        line_bit_en |=> (tx_frame_start == ($past(byte_ptr) == '0 && $past(bit_idx) == '0)));

    // A stalled step freezes the output and the position.
    assert_stall_hold_R9: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        !line_bit_en |=> ($stable(tx_bit) && $stable(tx_frame_start)
                          && $stable(byte_ptr) && $stable(bit_idx)));

endmodule

bind trail_trace_tx trail_trace_tx_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_chk (
    .host_clk       (host_clk),
    .host_rst_n     (host_rst_n),
    .host_wr_en     (host_wr_en),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .host_rdata     (host_rdata),
    .line_clk       (line_clk),
    .line_rst_n     (line_rst_n),
    .line_bit_en    (line_bit_en),
    .cfg_align      (cfg_align),
    .cfg_idle       (cfg_idle),
    .cfg_invert     (cfg_invert),
    .tx_bit         (tx_bit),
    .tx_frame_start (tx_frame_start),
    .byte_ptr       (byte_ptr),
    .bit_idx        (bit_idx)
);

// File: tb/test_trail_trace_tx.sv
// Bench for trail_trace_tx: a behavioural reference model steps with the
// line clock and is compared with the outputs on every falling edge.
module test_trail_trace_tx;

    logic       host_clk = 1'b0;
    logic       line_clk = 1'b0;
    logic       host_run = 1'b1;
    logic       line_run = 1'b1;
    logic       host_rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       line_rst_n = 1'b0;
    logic       line_bit_en = 1'b0;
    logic       cfg_reorder = 1'b0;
    logic       cfg_align = 1'b0;
    logic       cfg_idle = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       tx_bit;
    logic       tx_frame_start;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string cur_req = "R10";

    logic [7:0] ref_mem [16];
    int  m_byte = 0;
    int  m_bit = 0;
    logic m_tx = 1'b0;
    logic m_frame = 1'b0;
    bit  model_valid = 1'b0;

    trail_trace_tx i_trail_trace_tx (
        .host_clk       (host_clk),
        .host_rst_n     (host_rst_n),
        .host_wr_en     (host_wr_en),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .line_clk       (line_clk),
        .line_rst_n     (line_rst_n),
        .line_bit_en    (line_bit_en),
        .cfg_reorder    (cfg_reorder),
        .cfg_align      (cfg_align),
        .cfg_idle       (cfg_idle),
        .cfg_invert     (cfg_invert),
        .tx_bit         (tx_bit),
        .tx_frame_start (tx_frame_start)
    );

    // 100 MHz line clock, slower host clock; each can be held stopped.
    always begin
        #5;
        if (line_run) line_clk = ~line_clk;
    end
    always begin
        #8;
        if (host_run) host_clk = ~host_clk;
    end

    // Reference model of the host store.
    always @(posedge host_clk) begin
        if (host_rst_n && host_wr_en) ref_mem[host_addr] = host_wdata;
    end

    // Reference model of the line stream.
    always @(posedge line_clk) begin
        if (!line_rst_n) begin
            m_byte = 0; m_bit = 0; m_tx = 1'b0; m_frame = 1'b0;
            model_valid = 1'b1;
        end else if (line_bit_en) begin
            logic [7:0] b;
            logic v;
            b = ref_mem[m_byte];
            v = cfg_reorder ? b[m_bit] : b[7 - m_bit];
            if (cfg_align && m_bit == 0) v = (m_byte == 0);
            if (cfg_idle) v = 1'b0;
            if (cfg_invert) v = ~v;
            m_tx = v;
            m_frame = (m_byte == 0 && m_bit == 0);
            m_bit = m_bit + 1;
            if (m_bit == 8) begin
                m_bit = 0;
                m_byte = (m_byte + 1) % 16;
            end
        end
    end

    // Compare the outputs with the model away from the active edge.
    always @(negedge line_clk) begin
        if (model_valid && !finished) begin
            checks++;
            if (tx_bit !== m_tx) begin
                failures++;
                $display("FAIL %s tx_bit actual=%0b expected=%0b (byte %0d bit %0d)",
                         cur_req, tx_bit, m_tx, m_byte, m_bit);
            end
            checks++;
            if (tx_frame_start !== m_frame) begin
                failures++;
                $display("FAIL R8 tx_frame_start actual=%0b expected=%0b", tx_frame_start, m_frame);
            end
        end
    end

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge host_clk);
        host_addr = a[3:0]; host_wdata = d; host_wr_en = 1'b1;
        @(negedge host_clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_check(input int a, input logic [7:0] exp, input string req);
        @(negedge host_clk);
        host_addr = a[3:0];
        #1;
        checks++;
        if (host_rdata !== exp) begin
            failures++;
            $display("FAIL %s host_rdata[%0d] actual=%02h expected=%02h", req, a, host_rdata, exp);
        end
    endtask

    task automatic run_bits(input int n, input string req);
        @(negedge line_clk);
        cur_req = req;
        line_bit_en = 1'b1;
        repeat (n) @(negedge line_clk);
        line_bit_en = 1'b0;
    endtask

    task automatic set_mode(input logic ro, input logic al, input logic id, input logic iv);
        @(negedge line_clk);
        cfg_reorder = ro; cfg_align = al; cfg_idle = id; cfg_invert = iv;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge host_clk);
        // R10: reset state of the line outputs.
        checks++;
        if (tx_bit !== 1'b0 || tx_frame_start !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset outputs actual=%0b%0b expected=00", tx_bit, tx_frame_start);
        end
        // R1: writes during host reset are ignored.
        host_write(3, 8'h5A);
        host_rst_n = 1'b1;
        host_write(3, 8'hC3);
        host_write(3, 8'h00);
        host_check(3, 8'h00, "R1");
        @(negedge line_clk);
        line_rst_n = 1'b1;

        // R1: load the identifier and read every entry back.
        for (int i = 0; i < 16; i++) host_write(i, 8'((i * 37 + 11) ^ (i << 4)));
        for (int i = 0; i < 16; i++) host_check(i, ref_mem[i], "R1");
        host_write(15, 8'b0110_1001);
        host_check(15, 8'b0110_1001, "R1");

        // R3 and R8: plain stream, two full passes to see the wrap.
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        run_bits(256, "R3");
        // R4: reversed bit order.
        set_mode(1'b1, 1'b0, 1'b0, 1'b0);
        run_bits(128, "R4");
        // R5: alignment marker with each reorder setting.
        set_mode(1'b0, 1'b1, 1'b0, 1'b0);
        run_bits(128, "R5");
        set_mode(1'b1, 1'b1, 1'b0, 1'b0);
        run_bits(128, "R5");
        // R6: idle zeros.
        set_mode(1'b0, 1'b1, 1'b1, 1'b0);
        run_bits(64, "R6");
        // R7: idle plus inversion gives ones; inversion after alignment.
        set_mode(1'b0, 1'b0, 1'b1, 1'b1);
        run_bits(64, "R7");
        set_mode(1'b0, 1'b1, 1'b0, 1'b1);
        run_bits(136, "R7");
        set_mode(1'b1, 1'b0, 1'b0, 1'b1);
        run_bits(72, "R7");

        // R9: irregular step enable.
        set_mode(1'b0, 1'b1, 1'b0, 1'b0);
        cur_req = "R9";
        for (int i = 0; i < 200; i++) begin
            @(negedge line_clk);
            line_bit_en = ((i % 3) != 1) && ((i % 7) != 4);
        end
        @(negedge line_clk);
        line_bit_en = 1'b0;

        // R10: line reset in the middle of a byte.
        run_bits(45, "R10");
        @(negedge line_clk);
        cur_req = "R10";
        line_rst_n = 1'b0;
        @(negedge line_clk);
        line_rst_n = 1'b1;
        run_bits(40, "R10");

        // R2: both resets leave the memory alone.
        @(negedge host_clk);
        host_rst_n = 1'b0;
        @(negedge line_clk);
        line_rst_n = 1'b0;
        repeat (3) @(negedge host_clk);
        host_rst_n = 1'b1;
        @(negedge line_clk);
        line_rst_n = 1'b1;
        for (int i = 0; i < 16; i++) host_check(i, ref_mem[i], "R2");
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        run_bits(128, "R2");

        // R11: host access with the line clock stopped.
        @(negedge line_clk);
        line_run = 1'b0;
        for (int i = 0; i < 16; i++) host_write(i, 8'(8'hF0 - i * 9));
        for (int i = 0; i < 16; i++) host_check(i, ref_mem[i], "R11");
        line_run = 1'b1;
        // R11: line stream with the host clock stopped.
        @(negedge host_clk);
        host_run = 1'b0;
        set_mode(1'b1, 1'b1, 1'b0, 1'b0);
        run_bits(192, "R11");
        host_run = 1'b1;
        repeat (4) @(negedge line_clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule